// File: doc/BRIEF.md
# Tolerant Run-Length Byte Compressor

This block shortens a stream of byte samples by collapsing neighbouring samples that are close in value into one run. The first sample of a run is kept as that run's reference. Each later sample whose unsigned distance from the reference is no larger than the tolerance (default 1) makes the run one longer. A sample outside that window closes the run. The run then leaves the block as two bytes: the reference value first, then the run length. Slowly drifting sensor data therefore compresses well, and each reconstructed sample differs from the true sample by at most the tolerance.

Samples arrive from a synchronous input FIFO through a read strobe and an empty flag. The read data is valid in the cycle after the strobe. Output bytes go to an output FIFO through a write strobe, which is never raised while the full flag is set. A level enable starts a stream from idle. A finish level ends the stream once the input FIFO has drained: any pending run is written out, and the block goes back to idle.

Top module: `tol_rle_comp`

## Requirements
- R1: While rst_ni is low, and after it is released, in_rd_o and out_wr_o stay low until a stream is started.
- R2: In idle the block makes no reads and no writes while enable_i is 0. A cycle with enable_i at 1 starts a stream.
- R3: A sample joins the current run when the unsigned absolute difference from the run's first sample is at most TOL (1). The values 0 and 255 never join each other. The byte emitted for a run is always its first sample.
- R4: Each run produces exactly two output writes: the value byte, then the count byte. The sample that broke the run starts a new run with count 1.
- R5: The count saturates at 255. When a run already holds 255 samples, the pair is emitted and the next sample starts a new run, even when that sample is within tolerance.
- R6: finish_i acts only when the input FIFO is empty. With a run pending, the block writes that pair and returns to idle. With finish_i low, the pending run is held back. An empty stream produces no writes.
- R7: in_rd_o is high only when in_empty_i is low, and out_wr_o is high only when out_full_i is low. Output stalls do not change the output byte sequence.
- R8: The input byte on in_data_i is taken in the cycle after the read strobe that requested it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Starts a stream when the block is idle |
| finish_i | input | 1 | Ends the stream once the input FIFO is empty |
| in_empty_i | input | 1 | Input FIFO empty flag |
| in_data_i | input | DATA_W | Input FIFO read data, valid the cycle after in_rd_o |
| in_rd_o | output | 1 | Input FIFO read strobe |
| out_full_i | input | 1 | Output FIFO full flag |
| out_wr_o | output | 1 | Output FIFO write strobe |
| out_data_o | output | DATA_W | Output byte: a run value or a run count |

## Verification
A sample read by the strobe at one edge is registered by the bench's FIFO model at that edge. The block takes the sample at the next edge, so a merge costs two cycles per sample. For a closed run, the value byte is written no earlier than the second edge after the breaking sample was read, and the count byte follows at the next free edge. The bench therefore does not predict single cycles. Its FIFO models capture every strobe at the clock edge and sample outputs on the falling edge. Each compared stream is checked only after a wait that is longer than the worst-case path of two cycles per sample plus two per output byte, including stall cycles.

// File: rtl/tol_rle_pkg.sv
package tol_rle_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD1,
    ST_DAT1,
    ST_RD2,
    ST_DAT2,
    ST_FWD_VAL,
    ST_FWD_CNT
  } state_e;
endpackage

// File: rtl/tol_rle_cmp.sv
module tol_rle_cmp #(
  parameter int DATA_W = 8,
  parameter int TOL    = 1
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              hit_o
);
  logic [DATA_W-1:0] diff;

  // unsigned distance, no wrap at the range ends
  always_comb begin
    if (a_i >= b_i) diff = a_i - b_i;
    else            diff = b_i - a_i;
    hit_o = ({1'b0, diff} <= (DATA_W+1)'(TOL));
  end
endmodule

// File: rtl/tol_rle_run.sv
module tol_rle_run #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] din_i,
  input  logic              first_i,
  input  logic              cap_i,
  input  logic              merge_i,
  input  logic              restart_i,
  output logic [DATA_W-1:0] ref_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic              cnt_full_o
);
  logic [DATA_W-1:0] ref_q, smp_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= '0;
      smp_q <= '0;
      cnt_q <= '0;
    end else begin
      if (cap_i) smp_q <= din_i;
      if (first_i) begin
        ref_q <= din_i;
        cnt_q <= DATA_W'(1);
      end else if (restart_i) begin
        ref_q <= smp_q;
        cnt_q <= DATA_W'(1);
      end else if (merge_i) begin
        cnt_q <= cnt_q + DATA_W'(1);
      end
    end
  end

  assign ref_o      = ref_q;
  assign cnt_o      = cnt_q;
  assign cnt_full_o = &cnt_q;

  assert_merge_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    merge_i |=> (cnt_q == $past(cnt_q) + DATA_W'(1)));
  assert_no_merge_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    merge_i |-> !cnt_full_o);
  assert_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == DATA_W'(1)) && (ref_q == $past(smp_q)));
endmodule

// File: rtl/tol_rle_ctrl.sv
module tol_rle_ctrl
  import tol_rle_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   enable_i,
  input  logic   finish_i,
  input  logic   in_empty_i,
  input  logic   out_full_i,
  input  logic   join_i,
  output state_e state_o,
  output logic   in_rd_o,
  output logic   out_wr_o,
  output logic   sel_cnt_o,
  output logic   first_o,
  output logic   cap_o,
  output logic   merge_o,
  output logic   restart_o
);
  state_e state_q, state_d;
  logic   flush_q, flush_d;

  always_comb begin
    state_d   = state_q;
    flush_d   = flush_q;
    in_rd_o   = 1'b0;
    out_wr_o  = 1'b0;
    sel_cnt_o = 1'b0;
    first_o   = 1'b0;
    cap_o     = 1'b0;
    merge_o   = 1'b0;
    restart_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (enable_i) state_d = ST_RD1;
      ST_RD1: begin
        if (!in_empty_i) begin
          in_rd_o = 1'b1;
          state_d = ST_DAT1;
        end else if (finish_i) begin
          state_d = ST_IDLE;
        end
      end
      ST_DAT1: begin
        first_o = 1'b1;
        state_d = ST_RD2;
      end
      ST_RD2: begin
        // drain input before honouring finish
        if (!in_empty_i) begin
          in_rd_o = 1'b1;
          state_d = ST_DAT2;
        end else if (finish_i) begin
          flush_d = 1'b1;
          state_d = ST_FWD_VAL;
        end
      end
      ST_DAT2: begin
        cap_o = 1'b1;
        if (join_i) begin
          merge_o = 1'b1;
          state_d = ST_RD2;
        end else begin
          flush_d = 1'b0;
          state_d = ST_FWD_VAL;
        end
      end
      ST_FWD_VAL: begin
        if (!out_full_i) begin
          out_wr_o = 1'b1;
          state_d  = ST_FWD_CNT;
        end
      end
      ST_FWD_CNT: begin
        sel_cnt_o = 1'b1;
        if (!out_full_i) begin
          out_wr_o = 1'b1;
          if (flush_q) begin
            flush_d = 1'b0;
            state_d = ST_IDLE;
          end else begin
            restart_o = 1'b1;
            state_d   = ST_RD2;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      flush_q <= 1'b0;
    end else begin
      state_q <= state_d;
      flush_q <= flush_d;
    end
  end

  assign state_o = state_q;

  assert_rd_nonempty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_rd_o |-> !in_empty_i);
  assert_wr_notfull_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_wr_o |-> !out_full_i);
  assert_val_then_cnt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_wr_o && !sel_cnt_o) |=> (state_q == ST_FWD_CNT));
  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !enable_i) |=> (state_q == ST_IDLE) && !in_rd_o && !out_wr_o);
  assert_flush_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_wr_o && sel_cnt_o && flush_q) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/tol_rle_comp.sv
module tol_rle_comp
  import tol_rle_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TOL    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              finish_i,
  input  logic              in_empty_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_rd_o,
  input  logic              out_full_i,
  output logic              out_wr_o,
  output logic [DATA_W-1:0] out_data_o
);
  state_e            state;
  logic              sel_cnt, first, cap, merge, restart;
  logic              hit, cnt_full, join_run;
  logic [DATA_W-1:0] ref_val, cnt_val;

  tol_rle_cmp #(.DATA_W(DATA_W), .TOL(TOL)) u_cmp (
    .a_i(ref_val), .b_i(in_data_i), .hit_o(hit)
  );

  assign join_run = hit && !cnt_full;

  tol_rle_run #(.DATA_W(DATA_W)) u_run (
    .clk_i, .rst_ni, .din_i(in_data_i),
    .first_i(first), .cap_i(cap), .merge_i(merge), .restart_i(restart),
    .ref_o(ref_val), .cnt_o(cnt_val), .cnt_full_o(cnt_full)
  );

  tol_rle_ctrl u_ctrl (
    .clk_i, .rst_ni, .enable_i, .finish_i, .in_empty_i, .out_full_i,
    .join_i(join_run), .state_o(state), .in_rd_o, .out_wr_o,
    .sel_cnt_o(sel_cnt), .first_o(first), .cap_o(cap),
    .merge_o(merge), .restart_o(restart)
  );

  assign out_data_o = sel_cnt ? cnt_val : ref_val;

  // a count byte is never zero
  assert_cnt_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_wr_o && state == ST_FWD_CNT) |-> (out_data_o != '0));
endmodule

// File: tb/tol_rle_comp_test.sv
`timescale 1ns/1ps
module tol_rle_comp_test;
  localparam int NV = 6;
  localparam int MI = 16;
  localparam int MO = 8;
  localparam int VIN [NV][MI] = '{
    '{45,45,45,45,45,46,46,46,48,48,0,0,0,0,0,0},
    '{67,67,67,89,89,89,89,89,89,88,45,45,45,45,44,0},
    '{0,255,255,1,0,0,0,0,0,0,0,0,0,0,0,0},
    '{10,11,12,11,9,0,0,0,0,0,0,0,0,0,0,0},
    '{254,255,253,0,0,0,0,0,0,0,0,0,0,0,0,0},
    '{7,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0}};
  localparam int VIN_N [NV] = '{10, 15, 4, 5, 3, 1};
  localparam int VOUT [NV][MO] = '{
    '{45,8,48,2,0,0,0,0},
    '{67,3,89,7,45,5,0,0},
    '{0,1,255,2,1,1,0,0},
    '{10,2,12,2,9,1,0,0},
    '{254,3,0,0,0,0,0,0},
    '{7,1,0,0,0,0,0,0}};
  localparam int VOUT_N [NV] = '{4, 6, 6, 6, 2, 2};

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic enable_i = 1'b0, finish_i = 1'b0;
  logic in_empty_i, in_rd_o, out_full_i, out_wr_o;
  logic [7:0] in_data_i, out_data_o;

  logic [7:0] in_mem [512];
  logic [7:0] got [16];
  int exp_b [16];
  int in_len = 0, n_exp = 0;
  int in_idx, n_got, bad_rd, bad_wr, cyc;
  logic clr = 1'b1, stall_en = 1'b0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  tol_rle_comp uut (
    .clk_i, .rst_ni, .enable_i, .finish_i, .in_empty_i, .in_data_i,
    .in_rd_o, .out_full_i, .out_wr_o, .out_data_o
  );

  assign in_empty_i = (in_idx >= in_len);
  assign out_full_i = stall_en && (cyc % 3 != 2);

  // FIFO models
  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (clr) begin
      in_idx <= 0; n_got <= 0; bad_rd <= 0; bad_wr <= 0;
      in_data_i <= 8'h00;
    end else begin
      if (in_rd_o) begin
        if (in_empty_i) bad_rd <= bad_rd + 1;
        in_data_i <= in_mem[in_idx];
        in_idx <= in_idx + 1;
      end
      if (out_wr_o) begin
        if (out_full_i) bad_wr <= bad_wr + 1;
        if (n_got < 16) got[n_got] <= out_data_o;
        n_got <= n_got + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic reset_q();
    @(negedge clk_i) clr = 1'b1;
    @(negedge clk_i) clr = 1'b0;
  endtask

  task automatic pulse_en();
    @(negedge clk_i) enable_i = 1'b1;
    @(negedge clk_i) enable_i = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic cmp_out(input string req);
    chk(n_got == n_exp, req, n_got, n_exp);
    for (int k = 0; k < n_exp && k < n_got && k < 16; k++)
      chk(int'(got[k]) == exp_b[k], req, int'(got[k]), exp_b[k]);
    chk(in_idx == in_len, {req, " consumed"}, in_idx, in_len);
    chk(bad_rd == 0 && bad_wr == 0, "R7 handshake", bad_rd + bad_wr, 0);
  endtask

  task automatic run_full(input string req);
    finish_i = 1'b1;
    pulse_en();
    wait_n(4 * in_len + 8 * n_exp + 30);
    cmp_out(req);
  endtask

  initial begin
    cyc = 0;
    wait_n(3);
    // R1: reset state
    chk(in_rd_o == 1'b0 && out_wr_o == 1'b0, "R1 in reset", int'(in_rd_o), 0);
    rst_ni = 1'b1;
    reset_q();
    wait_n(2);
    chk(in_rd_o == 1'b0 && out_wr_o == 1'b0, "R1 after reset", int'(out_wr_o), 0);

    // vector table: R3 R4 R8 merging and pair order, odd rows with output stalls (R7)
    for (int v = 0; v < NV; v++) begin
      reset_q();
      in_len = VIN_N[v];
      n_exp = VOUT_N[v];
      for (int k = 0; k < MI; k++) in_mem[k] = 8'(VIN[v][k]);
      for (int k = 0; k < MO; k++) exp_b[k] = VOUT[v][k];
      stall_en = v[0];
      run_full($sformatf("R3/R4 vector %0d", v));
    end
    stall_en = 1'b0;

    // R2: no activity while enable low
    reset_q();
    in_len = 1; in_mem[0] = 8'd7; n_exp = 2; exp_b[0] = 7; exp_b[1] = 1;
    finish_i = 1'b1;
    wait_n(20);
    chk(in_idx == 0 && n_got == 0, "R2 enable low", in_idx + n_got, 0);
    pulse_en();
    wait_n(30);
    cmp_out("R2 after enable");

    // R6: finish low holds the pending run, raising it flushes
    reset_q();
    in_len = 10;
    for (int k = 0; k < 10; k++) in_mem[k] = 8'(VIN[0][k]);
    finish_i = 1'b0;
    pulse_en();
    wait_n(80);
    chk(n_got == 2, "R6 pending held", n_got, 2);
    n_exp = 4; exp_b[0] = 45; exp_b[1] = 8; exp_b[2] = 48; exp_b[3] = 2;
    finish_i = 1'b1;
    wait_n(20);
    cmp_out("R6 flush");

    // R6: empty stream writes nothing
    reset_q();
    in_len = 0; n_exp = 0;
    run_full("R6 empty");
    chk(n_got == 0, "R6 empty writes", n_got, 0);

    // R5: saturation at 255
    reset_q();
    in_len = 255;
    for (int k = 0; k < 255; k++) in_mem[k] = 8'd5;
    n_exp = 2; exp_b[0] = 5; exp_b[1] = 255;
    run_full("R5 exactly 255");

    reset_q();
    in_len = 301;
    for (int k = 0; k < 300; k++) in_mem[k] = 8'd5;
    in_mem[300] = 8'd9;
    n_exp = 6; exp_b[0] = 5; exp_b[1] = 255; exp_b[2] = 5; exp_b[3] = 45;
    exp_b[4] = 9; exp_b[5] = 1;
    stall_en = 1'b1;
    run_full("R5 split run");
    stall_en = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule